// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block moves received frames from a byte stream into host memory by way of a ring of 32-byte receive descriptors. When a frame begins and reception is enabled, the engine reads the descriptor at the current ring position. The descriptor gives an ownership flag, a wrap flag and the address of the first data buffer. The frame bytes are then stored one at a time into that buffer. Once the end marker arrives, the engine writes a status word into the descriptor. That word carries the frame length plus four bytes for a CRC that is never stored, and it leaves the ownership flag clear. The engine then steps or wraps the ring pointer, pulses status events and updates its traffic counters.

The frame input is a valid/ready byte stream with start and end markers. A byte is taken only on a cycle where both valid and ready are high. Ready is low while a frame start waits for reception to be enabled, and while any memory request is outstanding. That covers the descriptor fetch, each buffer byte write and the final descriptor write. The memory side is a request/response port. A request stays valid, with fixed fields, until the memory accepts it. Writes get no response. Each read returns exactly one response word, on a later cycle.

Top module: `rx_desc_writeback`

## Requirements
- R1: While `rx_enable` is low, a byte marked as a frame start is not taken (`s_ready` stays 0) and no memory request is made.
- R2: On a frame start, the engine reads descriptor words at pointer +0, +4 and +8. Bit 31 of word +0 is ownership, bit 15 of word +4 is the wrap flag, and word +8 is the buffer address. Byte n of an owned frame is written to buffer address + n, using the byte lane selected by the low two address bits.
- R3: A frame shorter than 12 bytes is discarded. There is no descriptor write, the pointer and counters are unchanged, and `ev_rx_done` and `ev_normal` pulse.
- R4: A frame of 12 or more bytes whose descriptor has bit 31 clear is consumed and dropped. There is no descriptor write, the pointer and counters are unchanged, and `ev_buf_unavail` and `ev_abnormal` pulse.
- R5: An accepted frame of length L writes ((L+4) << 16) | 0x300 to descriptor word +0, which leaves bit 31 clear.
- R6: After that write, the pointer reloads from the ring base if the wrap flag was set, and otherwise advances by 32. A `ring_base_load` pulse sets both the ring base and the pointer to `ring_base`.
- R7: An accepted frame pulses `ev_rx_done` and `ev_normal`, adds L+4 to the 64-bit `byte_count` and increments `frame_count`.
- R8: A frame whose first six bytes are all 0xFF is broadcast. A frame whose first byte has bit 0 set and is not broadcast is multicast. Any other frame is unicast. Accepted broadcast and multicast frames also increment `bcast_count` and `mcast_count` respectively.
- R9: `s_ready` is low on every cycle on which a memory request is pending.
- R10: After reset, the pointer and all counters are 0, no memory request is valid, and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Reception enable |
| ring_base | input | AW | Ring base address |
| ring_base_load | input | 1 | Load ring base and pointer |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte ready |
| s_data | input | 8 | Stream byte |
| s_first | input | 1 | Byte is first of a frame |
| s_last | input | 1 | Byte is last of a frame |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | AW | Byte address |
| mem_req_be | output | 4 | Byte lane enables |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | 32 | Read response data |
| cur_desc_ptr | output | AW | Current descriptor pointer |
| ev_rx_done | output | 1 | Receive-complete event pulse |
| ev_normal | output | 1 | Normal-summary event pulse |
| ev_buf_unavail | output | 1 | Buffer-unavailable event pulse |
| ev_abnormal | output | 1 | Abnormal-summary event pulse |
| byte_count | output | 64 | Received bytes, CRC included |
| frame_count | output | CNT_W | Accepted frames |
| mcast_count | output | CNT_W | Accepted multicast frames |
| bcast_count | output | CNT_W | Accepted broadcast frames |

## Verification
Several frame patterns pass through the ring.

- Owned unicast, multicast and broadcast frames show whether classification and the status word follow the first bytes and the length.
- A frame of exactly 12 bytes and frames of 11 and 6 bytes separate the runt threshold from the accepted case.
- A descriptor with ownership clear separates the unavailable path from a runt discard.
- A wrap-flagged descriptor and a base reload show that the pointer returns to the base rather than stepping.

The memory accepts requests only some of the time, so the back-pressure is exercised. The bench also holds off a frame start while reception is disabled.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_DATA, ST_END, ST_WB
  } rxwb_state_e;

  localparam int DESC_STRIDE = 32;
  localparam int OWN_BIT     = 31;
  localparam int WRAP_BIT    = 15;
  localparam int MIN_FRAME   = 12;
  localparam int CRC_LEN     = 4;
  localparam int HDR_BYTES   = 6;
  localparam int RPT_W       = 16;
  localparam logic [15:0] STAT_LOW = 16'h0300;
endpackage

// File: rtl/rxwb_classify.sv
module rxwb_classify #(
  parameter int HDR = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       take,
  input  logic [7:0] data,
  output logic       is_bcast,
  output logic       is_mcast
);
  localparam int PW = $clog2(HDR + 1);
  localparam logic [PW-1:0] HDR_P = PW'(HDR);

  logic [PW-1:0] pos;
  logic          grp;
  logic          all_ff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      grp    <= 1'b0;
      all_ff <= 1'b1;
    end else if (clr) begin
      pos    <= '0;
      grp    <= 1'b0;
      all_ff <= 1'b1;
    end else if (take && pos < HDR_P) begin
      if (pos == '0) grp <= data[0];
      all_ff <= all_ff && (data == 8'hFF);
      pos    <= pos + 1'b1;
    end
  end

  assign is_bcast = all_ff && (pos == HDR_P);
  assign is_mcast = grp && !is_bcast;
endmodule

// File: rtl/rxwb_counters.sv
module rxwb_counters #(
  parameter int CNT_W  = 32,
  parameter int BYTE_W = 64,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bump,
  input  logic [LEN_W-1:0]  add_len,
  input  logic              is_bcast,
  input  logic              is_mcast,
  output logic [BYTE_W-1:0] byte_total,
  output logic [CNT_W-1:0]  frame_total,
  output logic [CNT_W-1:0]  mcast_total,
  output logic [CNT_W-1:0]  bcast_total
);
  logic [1:0] cls_hit;
  logic [CNT_W-1:0] cls_cnt [2];
  assign cls_hit = {is_bcast, is_mcast};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_total  <= '0;
      frame_total <= '0;
    end else if (bump) begin
      byte_total  <= byte_total + BYTE_W'(add_len);
      frame_total <= frame_total + 1'b1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_cls
    always_ff @(posedge clk) begin
      if (!rst_n)                 cls_cnt[g] <= '0;
      else if (bump && cls_hit[g]) cls_cnt[g] <= cls_cnt[g] + 1'b1;
    end
  end

  assign mcast_total = cls_cnt[0];
  assign bcast_total = cls_cnt[1];
endmodule

// File: rtl/rx_desc_writeback.sv
module rx_desc_writeback
  import rxwb_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 14,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic [AW-1:0]    ring_base,
  input  logic             ring_base_load,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_first,
  input  logic             s_last,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic             mem_req_write,
  output logic [AW-1:0]    mem_req_addr,
  output logic [3:0]       mem_req_be,
  output logic [31:0]      mem_req_wdata,
  input  logic             mem_rsp_valid,
  input  logic [31:0]      mem_rsp_rdata,
  output logic [AW-1:0]    cur_desc_ptr,
  output logic             ev_rx_done,
  output logic             ev_normal,
  output logic             ev_buf_unavail,
  output logic             ev_abnormal,
  output logic [63:0]      byte_count,
  output logic [CNT_W-1:0] frame_count,
  output logic [CNT_W-1:0] mcast_count,
  output logic [CNT_W-1:0] bcast_count
);
  rxwb_state_e        state;
  logic [1:0]         widx;
  logic               own_q, wrap_q;
  logic [AW-1:0]      buf_q, base_q, ptr_q;
  logic [LEN_W-1:0]   len_q;
  logic               wr_pend;
  logic [AW-1:0]      wr_addr;
  logic [7:0]         wr_byte;
  logic [RPT_W-1:0]   rpt_len;
  logic               take, data_take, start_frame, mem_fire, wb_done;
  logic               is_bcast, is_mcast;

  assign rpt_len     = RPT_W'(len_q) + RPT_W'(CRC_LEN);
  assign start_frame = (state == ST_IDLE) && rx_enable && s_valid && s_first;
  assign s_ready     = (state == ST_IDLE) ? (rx_enable && !s_first)
                                          : ((state == ST_DATA) && !wr_pend);
  assign take        = s_valid && s_ready;
  assign data_take   = take && (state == ST_DATA);
  assign mem_fire    = mem_req_valid && mem_req_ready;
  assign wb_done     = (state == ST_WB) && mem_fire;
  assign cur_desc_ptr = ptr_q;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    mem_req_be    = 4'h0;
    mem_req_wdata = '0;
    case (state)
      ST_RD_REQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = ptr_q + AW'({widx, 2'b00});
        mem_req_be    = 4'hF;
      end
      ST_DATA, ST_END: begin
        mem_req_valid = wr_pend;
        mem_req_write = 1'b1;
        mem_req_addr  = wr_addr;
        mem_req_be    = 4'b0001 << wr_addr[1:0];
        mem_req_wdata = {4{wr_byte}};
      end
      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = ptr_q;
        mem_req_be    = 4'hF;
        mem_req_wdata = {rpt_len, STAT_LOW};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      widx           <= '0;
      own_q          <= 1'b0;
      wrap_q         <= 1'b0;
      buf_q          <= '0;
      base_q         <= '0;
      ptr_q          <= '0;
      len_q          <= '0;
      wr_pend        <= 1'b0;
      wr_addr        <= '0;
      wr_byte        <= '0;
      ev_rx_done     <= 1'b0;
      ev_normal      <= 1'b0;
      ev_buf_unavail <= 1'b0;
      ev_abnormal    <= 1'b0;
    end else begin
      ev_rx_done     <= 1'b0;
      ev_normal      <= 1'b0;
      ev_buf_unavail <= 1'b0;
      ev_abnormal    <= 1'b0;
      case (state)
        ST_IDLE: if (start_frame) begin
          state <= ST_RD_REQ;
          widx  <= '0;
          len_q <= '0;
        end
        ST_RD_REQ: if (mem_fire) state <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid) begin
          case (widx)
            2'd0:    own_q  <= mem_rsp_rdata[OWN_BIT];
            2'd1:    wrap_q <= mem_rsp_rdata[WRAP_BIT];
            default: buf_q  <= AW'(mem_rsp_rdata);
          endcase
          if (widx == 2'd2) state <= ST_DATA;
          else begin
            widx  <= widx + 1'b1;
            state <= ST_RD_REQ;
          end
        end
        ST_DATA: begin
          if (wr_pend && mem_fire) wr_pend <= 1'b0;
          if (data_take) begin
            len_q <= len_q + 1'b1;
            if (own_q) begin
              wr_pend <= 1'b1;
              wr_addr <= buf_q + AW'(len_q);
              wr_byte <= s_data;
            end
            if (s_last) state <= ST_END;
          end
        end
        ST_END: begin
          if (wr_pend) begin
            if (mem_fire) wr_pend <= 1'b0;
          end else if (len_q < LEN_W'(MIN_FRAME)) begin
            ev_rx_done <= 1'b1;
            ev_normal  <= 1'b1;
            state      <= ST_IDLE;
          end else if (!own_q) begin
            ev_buf_unavail <= 1'b1;
            ev_abnormal    <= 1'b1;
            state          <= ST_IDLE;
          end else begin
            state <= ST_WB;
          end
        end
        ST_WB: if (mem_fire) begin
          ptr_q      <= wrap_q ? base_q : ptr_q + AW'(DESC_STRIDE);
          ev_rx_done <= 1'b1;
          ev_normal  <= 1'b1;
          state      <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (ring_base_load) begin
        base_q <= ring_base;
        ptr_q  <= ring_base;
      end
    end
  end

  rxwb_classify #(.HDR(HDR_BYTES)) u_cls (
    .clk(clk), .rst_n(rst_n), .clr(start_frame), .take(data_take),
    .data(s_data), .is_bcast(is_bcast), .is_mcast(is_mcast)
  );

  rxwb_counters #(.CNT_W(CNT_W), .BYTE_W(64), .LEN_W(RPT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .bump(wb_done), .add_len(rpt_len),
    .is_bcast(is_bcast), .is_mcast(is_mcast),
    .byte_total(byte_count), .frame_total(frame_count),
    .mcast_total(mcast_count), .bcast_total(bcast_count)
  );
endmodule

// File: rtl/rxwb_checker.sv
module rxwb_checker #(
  parameter int AW    = 32,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ring_base_load,
  input logic             s_ready,
  input logic             mem_req_valid,
  input logic             mem_req_write,
  input logic [3:0]       mem_req_be,
  input logic [31:0]      mem_req_wdata,
  input logic [AW-1:0]    cur_desc_ptr,
  input logic             ev_rx_done,
  input logic             ev_buf_unavail,
  input logic [63:0]      byte_count,
  input logic [CNT_W-1:0] frame_count,
  input logic [CNT_W-1:0] mcast_count,
  input logic [CNT_W-1:0] bcast_count
);
  AST_NO_TAKE_WHILE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !s_ready); // R9

  AST_WB_WORD_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write && mem_req_be == 4'hF)
      |-> (mem_req_wdata[15:0] == 16'h0300 && !mem_req_wdata[31])); // R5

  AST_PTR_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_desc_ptr != $past(cur_desc_ptr) && !$past(ring_base_load))
      |-> ev_rx_done); // R6

  AST_FRAME_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_count != $past(frame_count))
      |-> (ev_rx_done && frame_count == $past(frame_count) + 1'b1)); // R7

  AST_BYTE_CNT_MIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_count != $past(byte_count))
      |-> (byte_count - $past(byte_count) >= 64'd16)); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_rx_done, ev_buf_unavail})); // R4

  AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mcast_count != $past(mcast_count) && bcast_count != $past(bcast_count))); // R8
endmodule

bind rx_desc_writeback rxwb_checker #(.AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ring_base_load(ring_base_load),
  .s_ready(s_ready), .mem_req_valid(mem_req_valid),
  .mem_req_write(mem_req_write), .mem_req_be(mem_req_be),
  .mem_req_wdata(mem_req_wdata), .cur_desc_ptr(cur_desc_ptr),
  .ev_rx_done(ev_rx_done), .ev_buf_unavail(ev_buf_unavail),
  .byte_count(byte_count), .frame_count(frame_count),
  .mcast_count(mcast_count), .bcast_count(bcast_count)
);

// File: tb/rx_desc_writeback_test.sv
`timescale 1ns/100ps
module rx_desc_writeback_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_enable = 1'b0;
  logic [31:0] ring_base = '0;
  logic        ring_base_load = 1'b0;
  logic        s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        mem_req_valid, mem_req_write, mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = '0;
  logic [31:0] cur_desc_ptr;
  logic        ev_rx_done, ev_normal, ev_buf_unavail, ev_abnormal;
  logic [63:0] byte_count;
  logic [31:0] frame_count, mcast_count, bcast_count;

  int total = 0, bad = 0;
  int n_done = 0, n_norm = 0, n_unav = 0, n_abn = 0, bp_bad = 0;
  logic [7:0] mem [0:1023];
  logic [1:0] cyc = '0;
  logic        hw_en = 1'b0;
  logic [9:0]  hw_addr = '0;
  logic [31:0] hw_data = '0;

  always #2.5 clk = ~clk;

  rx_desc_writeback uut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .ring_base(ring_base),
    .ring_base_load(ring_base_load), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_first(s_first), .s_last(s_last),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_be(mem_req_be), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .cur_desc_ptr(cur_desc_ptr), .ev_rx_done(ev_rx_done), .ev_normal(ev_normal),
    .ev_buf_unavail(ev_buf_unavail), .ev_abnormal(ev_abnormal),
    .byte_count(byte_count), .frame_count(frame_count),
    .mcast_count(mcast_count), .bcast_count(bcast_count)
  );

  assign mem_req_ready = (cyc != 2'b11);

  // memory model: one always block owns the array
  always @(posedge clk) begin
    cyc <= cyc + 1'b1;
    mem_rsp_valid <= 1'b0;
    if (hw_en) begin
      for (int b = 0; b < 4; b++) mem[hw_addr + 10'(b)] <= hw_data[8*b +: 8];
    end
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        for (int b = 0; b < 4; b++)
          if (mem_req_be[b]) mem[{mem_req_addr[9:2], 2'(b)}] <= mem_req_wdata[8*b +: 8];
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= {mem[{mem_req_addr[9:2], 2'd3}], mem[{mem_req_addr[9:2], 2'd2}],
                          mem[{mem_req_addr[9:2], 2'd1}], mem[{mem_req_addr[9:2], 2'd0}]};
      end
    end
  end

  always @(posedge clk) begin
    if (ev_rx_done) n_done++;
    if (ev_normal) n_norm++;
    if (ev_buf_unavail) n_unav++;
    if (ev_abnormal) n_abn++;
  end

  always @(negedge clk) if (rst_n && mem_req_valid && s_ready) bp_bad++;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd32(logic [9:0] a);
    return {mem[a+10'd3], mem[a+10'd2], mem[a+10'd1], mem[a]};
  endfunction

  function automatic logic [7:0] fbyte(int kind, int i);
    if (kind == 2 && i < 6) return 8'hFF;
    if (i == 0) return (kind == 1) ? 8'h01 : 8'h02;
    return 8'(i * 7 + 3);
  endfunction

  task automatic host_wr(logic [9:0] a, logic [31:0] d);
    @(negedge clk); hw_en = 1'b1; hw_addr = a; hw_data = d;
    @(negedge clk); hw_en = 1'b0;
  endtask

  task automatic send_frame(int len, int kind);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_data = fbyte(kind, i);
      s_first = (i == 0); s_last = (i == len - 1);
      do @(posedge clk); while (!s_ready);
    end
    @(negedge clk); s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
  endtask

  // {len[7:0], kind[1:0] (0 uni,1 mcast,2 bcast), owned, wrap}
  localparam logic [11:0] VEC [7] = '{
    {8'd20, 2'd0, 1'b1, 1'b0},
    {8'd64, 2'd1, 1'b1, 1'b0},
    {8'd12, 2'd2, 1'b1, 1'b1},
    {8'd30, 2'd0, 1'b0, 1'b0},
    {8'd11, 2'd0, 1'b1, 1'b0},
    {8'd6,  2'd2, 1'b1, 1'b0},
    {8'd13, 2'd1, 1'b1, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] eptr;
    longint ebytes = 0;
    int eframes = 0, emc = 0, ebc = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10", "ptr", cur_desc_ptr, 0);
    chk("R10", "frames", frame_count, 0);
    chk("R10", "bytes", byte_count, 0);
    chk("R10", "req_valid", mem_req_valid, 0);

    // R6 base load
    ring_base = 32'h180; ring_base_load = 1'b1;
    @(negedge clk); ring_base_load = 1'b0;
    chk("R6", "ptr after base load", cur_desc_ptr, 32'h180);
    ring_base = 32'h100; ring_base_load = 1'b1;
    @(negedge clk); ring_base_load = 1'b0;
    eptr = 32'h100;
    rx_enable = 1'b1;

    for (int k = 0; k < 7; k++) begin
      int len, kind, own, wrap, d0, du, bp0;
      logic [9:0] buf_a, da;
      len = int'(VEC[k][11:4]); kind = int'(VEC[k][3:2]);
      own = int'(VEC[k][1]); wrap = int'(VEC[k][0]);
      da = eptr[9:0]; buf_a = 10'(32'h200 + k * 32'h40);
      host_wr(da, own ? 32'h8000_0000 : 32'h0);
      host_wr(da + 10'd4, wrap ? 32'h0000_8600 : 32'h0000_0600);
      host_wr(da + 10'd8, {22'd0, buf_a});
      d0 = n_done; du = n_unav; bp0 = bp_bad;
      send_frame(len, kind);
      do @(posedge clk); while (!(ev_rx_done || ev_buf_unavail));
      @(negedge clk);
      chk("R9", "accept during memory request", bp_bad - bp0, 0);
      if (len < 12) begin
        chk("R3", "runt done events", n_done - d0, 1);
        chk("R3", "runt desc untouched", rd32(da), own ? 32'h8000_0000 : 0);
        chk("R3", "runt ptr", cur_desc_ptr, eptr);
      end else if (own == 0) begin
        chk("R4", "unavail events", n_unav - du, 1);
        chk("R4", "no done event", n_done - d0, 0);
        chk("R4", "desc untouched", rd32(da), 0);
        chk("R4", "ptr", cur_desc_ptr, eptr);
      end else begin
        chk("R5", "status word", rd32(da), ((len + 4) << 16) | 32'h300);
        chk("R2", "first buffer byte", mem[buf_a], fbyte(kind, 0));
        chk("R2", "last buffer byte", mem[buf_a + 10'(len - 1)], fbyte(kind, len - 1));
        chk("R7", "done events", n_done - d0, 1);
        eptr = wrap ? 32'h100 : eptr + 32;
        chk("R6", "ptr step", cur_desc_ptr, eptr);
        ebytes += len + 4; eframes++;
        if (kind == 1) emc++;
        if (kind == 2) ebc++;
      end
      chk("R7", "normal events match done", n_norm, n_done);
      chk("R4", "abnormal events match unavail", n_abn, n_unav);
      chk("R7", "byte count", byte_count, ebytes);
      chk("R7", "frame count", frame_count, eframes);
      chk("R8", "mcast count", mcast_count, emc);
      chk("R8", "bcast count", bcast_count, ebc);
    end

    // R1 disabled: frame start held off
    begin
      int seen = 0;
      rx_enable = 1'b0;
      @(negedge clk);
      s_valid = 1'b1; s_first = 1'b1; s_data = 8'h02;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (s_ready || mem_req_valid) seen++;
      end
      chk("R1", "ready or request while disabled", seen, 0);
      s_valid = 1'b0; s_first = 1'b0;
      @(negedge clk);
      chk("R1", "frames unchanged", frame_count, eframes);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule